// File: doc/BRIEF.md
# 3B/4B Line Codec with Frame Alignment

This block carries both ends of a 3-bit to 4-bit line code. On the transmit side it turns each 3-bit data word into a 4-bit code word. On request it sends the four-word alignment sequence instead. Code words are tagged even or odd by their place in the stream. Two of the eight data values, and both sync symbols, use a different code word in each of the two positions, so the running disparity stays bounded and runs of identical bits stay short.

On the receive side the block takes a serial bit stream, one bit per enabled cycle. It slides a 16-bit window over the stream until the whole alignment sequence appears. From that point it cuts the stream into 4-bit words at the offset it found. Each word is decoded against its expected position. Data words come out as 3-bit values, sync words are absorbed silently, and words that are illegal in their position raise an error flag. If too many errors pile up, alignment is dropped and the search starts again.

Top module: `lc34_codec`

## Requirements
- R1: A data input of 000, 001, 010, 011, 100 or 101 is sent as 0011, 0101, 0110, 1001, 1010 or 1100 respectively, in either word position.
- R2: Data 110 is sent as 0100 in an even position and 1011 in an odd position. Data 111 is sent as 0010 in an even position and 1101 in an odd position.
- R3: Each emitted word appears on `tx_code` with `tx_code_vld` high for one cycle, one clock after the input cycle. The position toggles after every emitted word. Cycles with `tx_valid` and `tx_sync` both low emit nothing and leave the position unchanged.
- R4: While `tx_sync` is high, one sync word is emitted per cycle, and `tx_valid` is ignored. The words follow the order 0111 (even), 1110 (odd), 1000 (even), 0001 (odd), then wrap. The order restarts at its first word whenever `tx_sync` has been low, and that first word forces the position to even.
- R5: The serialised encoder output, sent most significant bit first, never holds more than 6 identical bits in a row.
- R6: The receiver takes `rx_bit` only in cycles where `rx_bit_vld` is high, first bit of a word being its MSB. `rx_aligned` rises in the cycle after the bit that completes the 16-bit pattern 0111_1110_1000_0001, at any bit offset.
- R7: Once aligned, every fourth accepted bit closes a word. The first word after alignment is even, and the position then alternates. A legal data word gives `rx_data` with a one-cycle `rx_vld` pulse in the cycle after its last bit.
- R8: A sync word that is legal for its position produces neither `rx_vld` nor `rx_err`.
- R9: A word that is illegal for its position (including 0000, 1111, and any position-specific code in the wrong position) gives a one-cycle `rx_err` pulse with `rx_vld` low.
- R10: Words are counted in back-to-back windows of 64 starting at alignment, and the error count restarts with each window. The 8th error inside one window clears `rx_aligned` in the same cycle as that error's pulse.
- R11: After reset `tx_code_vld`, `rx_vld`, `rx_err` and `rx_aligned` are low.
- R12: While not aligned, the receiver emits neither `rx_vld` nor `rx_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 3 | Data word to encode |
| tx_valid | input | 1 | Encode `tx_data` this cycle |
| tx_sync | input | 1 | Emit the next word of the alignment sequence this cycle |
| tx_code | output | 4 | Encoded word, MSB sent first |
| tx_code_vld | output | 1 | `tx_code` holds a new word |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_vld | input | 1 | `rx_bit` is taken this cycle |
| rx_data | output | 3 | Decoded data word |
| rx_vld | output | 1 | `rx_data` holds a new word |
| rx_err | output | 1 | Last word closed was illegal for its position |
| rx_aligned | output | 1 | Word boundary is locked |

## Verification
The encoder result is due exactly one clock after its input cycle. The bench drives on the falling edge and compares at the next falling edge against a queue filled by the driver. Receiver results (`rx_vld`, `rx_err`, and the rise or fall of `rx_aligned`) are due one clock after the edge that accepts the closing bit, so the bench samples them at the falling edge right after that bit and never during idle gaps. The encoder output is looped back through a random bit slip and gapped enables. An error burst is laid across a 64-word window boundary, so that both the window restart and the eighth-error drop land on cycles known in advance.

// File: rtl/lc34_pkg.sv
// Package: code tables and word classification shared by the encoder and
// the receive framer. Assumes 3-bit data, 4-bit code words, MSB sent first.
package lc34_pkg;

    localparam int DATA_W     = 3;
    localparam int CODE_W     = 4;
    localparam int SYNC_WORDS = 4;
    localparam int SYNC_BITS  = SYNC_WORDS * CODE_W;

    // Full alignment sequence as it appears on the wire, oldest bit at MSB
    localparam logic [SYNC_BITS-1:0] SYNC_PATTERN = 16'b0111_1110_1000_0001;

    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_SYNC = 2'd1,
        WK_BAD  = 2'd2
    } word_kind_e;

    typedef struct packed {
        word_kind_e          kind;
        logic [DATA_W-1:0]   data;
    } word_info_t;

    // Code word for a data value at a given position (odd = 1)
    function automatic logic [CODE_W-1:0] enc_word(logic [DATA_W-1:0] d, logic odd);
        logic [CODE_W-1:0] r;
        case (d)
            3'd0:    r = 4'b0011;
            3'd1:    r = 4'b0101;
            3'd2:    r = 4'b0110;
            3'd3:    r = 4'b1001;
            3'd4:    r = 4'b1010;
            3'd5:    r = 4'b1100;
            3'd6:    r = odd ? 4'b1011 : 4'b0100;
            default: r = odd ? 4'b1101 : 4'b0010;
        endcase
        return r;
    endfunction

    // Sync word by its index in the alignment sequence
    function automatic logic [CODE_W-1:0] sync_word(logic [1:0] idx);
        return SYNC_PATTERN[(SYNC_BITS-1) - CODE_W*idx -: CODE_W];
    endfunction

    // Classify a received word against its expected position
    function automatic word_info_t dec_word(logic [CODE_W-1:0] w, logic odd);
        word_info_t r;
        r.kind = WK_DATA;
        r.data = '0;
        case (w)
            4'b0011: r.data = 3'd0;
            4'b0101: r.data = 3'd1;
            4'b0110: r.data = 3'd2;
            4'b1001: r.data = 3'd3;
            4'b1010: r.data = 3'd4;
            4'b1100: r.data = 3'd5;
            4'b0100: begin r.data = 3'd6; if (odd)  r.kind = WK_BAD; end
            4'b1011: begin r.data = 3'd6; if (!odd) r.kind = WK_BAD; end
            4'b0010: begin r.data = 3'd7; if (odd)  r.kind = WK_BAD; end
            4'b1101: begin r.data = 3'd7; if (!odd) r.kind = WK_BAD; end
            4'b0111: r.kind = odd ? WK_BAD : WK_SYNC;
            4'b1000: r.kind = odd ? WK_BAD : WK_SYNC;
            4'b1110: r.kind = odd ? WK_SYNC : WK_BAD;
            4'b0001: r.kind = odd ? WK_SYNC : WK_BAD;
            default: r.kind = WK_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lc34_word_dec.sv
// Word classifier: combinational decode of one 4-bit word at a known
// position into data, sync or illegal. Assumes the caller supplies the
// position parity of the word being closed.
module lc34_word_dec
    import lc34_pkg::*;
(
    input  logic [CODE_W-1:0] word,
    input  logic              odd,
    output word_info_t        info
);

    // Table lookup through the shared classification function
    always_comb begin
        info = dec_word(word, odd);
    end

endmodule

// File: rtl/lc34_enc.sv
// Transmit encoder: maps a 3-bit word to its position-dependent 4-bit code,
// or emits the next word of the alignment sequence while a sync request is
// held. Output is registered; one word per accepted cycle. Assumes the
// consumer takes every word in the cycle it is presented.
module lc34_enc
    import lc34_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_sync,
    output logic [CODE_W-1:0] tx_code,
    output logic              tx_code_vld
);

    logic       odd_q;     // position of the next emitted word
    logic [1:0] sidx_q;    // index into the alignment sequence

    // Position tracking and sequence index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q  <= 1'b0;
            sidx_q <= '0;
        end else if (tx_sync) begin
            odd_q  <= (sidx_q == 2'd0) ? 1'b1 : ~odd_q;
            sidx_q <= sidx_q + 2'd1;
        end else begin
            sidx_q <= '0;
            if (tx_valid) begin
                odd_q <= ~odd_q;
            end
        end
    end

    // Registered code word output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_code     <= '0;
            tx_code_vld <= 1'b0;
        end else begin
            tx_code_vld <= tx_sync | tx_valid;
            if (tx_sync) begin
                tx_code <= sync_word(sidx_q);
            end else if (tx_valid) begin
                tx_code <= enc_word(tx_data, odd_q);
            end
        end
    end

endmodule

// File: rtl/lc34_rx_framer.sv
// Receive framer: shifts serial bits into a window, hunts for the full
// alignment sequence, then closes a word every fourth accepted bit and
// decodes it at its position. Errors are counted per window of words;
// reaching the limit inside one window drops alignment. Assumes the first
// bit of each word on the wire is its MSB.
module lc34_rx_framer
    import lc34_pkg::*;
#(
    parameter int ERR_LIMIT = 8,
    parameter int WIN_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_vld,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_vld,
    output logic              rx_err,
    output logic              rx_aligned
);

    localparam int EW  = $clog2(ERR_LIMIT + 1);
    localparam int WW  = $clog2(WIN_WORDS);
    localparam int BCW = $clog2(CODE_W);

    logic [SYNC_BITS-1:0] shreg_q;
    logic [SYNC_BITS-1:0] window;
    logic [BCW-1:0]       bitcnt_q;
    logic                 odd_q;
    logic [WW-1:0]        wcnt_q;
    logic [EW-1:0]        ecnt_q;
    logic                 word_end;
    logic                 bad;
    logic                 limit_hit;
    word_info_t           info;

    assign window    = {shreg_q[SYNC_BITS-2:0], rx_bit};
    assign word_end  = rx_aligned && rx_bit_vld && (bitcnt_q == BCW'(CODE_W - 1));
    assign bad       = (info.kind == WK_BAD);
    assign limit_hit = bad && ((int'(ecnt_q) + 1) >= ERR_LIMIT);

    lc34_word_dec u_dec (
        .word (window[CODE_W-1:0]),
        .odd  (odd_q),
        .info (info)
    );

    // Serial shift window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (rx_bit_vld) begin
            shreg_q <= window;
        end
    end

    // Alignment state, bit position and word position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_aligned <= 1'b0;
            bitcnt_q   <= '0;
            odd_q      <= 1'b0;
        end else if (rx_bit_vld) begin
            if (!rx_aligned) begin
                if (window == SYNC_PATTERN) begin
                    rx_aligned <= 1'b1;
                    bitcnt_q   <= '0;
                    odd_q      <= 1'b0;
                end
            end else begin
                bitcnt_q <= bitcnt_q + BCW'(1);
                if (word_end) begin
                    odd_q <= ~odd_q;
                    if (limit_hit) begin
                        rx_aligned <= 1'b0;
                    end
                end
            end
        end
    end

    // Error window bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            ecnt_q <= '0;
        end else if (rx_bit_vld && !rx_aligned) begin
            wcnt_q <= '0;
            ecnt_q <= '0;
        end else if (word_end) begin
            if (limit_hit || (wcnt_q == WW'(WIN_WORDS - 1))) begin
                wcnt_q <= '0;
                ecnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + WW'(1);
                ecnt_q <= ecnt_q + {{(EW-1){1'b0}}, bad};
            end
        end
    end

    // Registered decode results, one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_vld  <= 1'b0;
            rx_err  <= 1'b0;
        end else begin
            rx_vld <= word_end && (info.kind == WK_DATA);
            rx_err <= word_end && bad;
            if (word_end && (info.kind == WK_DATA)) begin
                rx_data <= info.data;
            end
        end
    end

endmodule

// File: rtl/lc34_codec.sv
// Top: 3B/4B line codec. Transmit encoder and receive framer share no
// state; the transmit path is parallel, the receive path serial. Assumes a
// single clock domain for both directions.
module lc34_codec
    import lc34_pkg::*;
#(
    parameter int ERR_LIMIT = 8,
    parameter int WIN_WORDS = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   tx_data,
    input  logic         tx_valid,
    input  logic         tx_sync,
    output logic [3:0]   tx_code,
    output logic         tx_code_vld,
    input  logic         rx_bit,
    input  logic         rx_bit_vld,
    output logic [2:0]   rx_data,
    output logic         rx_vld,
    output logic         rx_err,
    output logic         rx_aligned
);

    lc34_enc u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_sync     (tx_sync),
        .tx_code     (tx_code),
        .tx_code_vld (tx_code_vld)
    );

    lc34_rx_framer #(
        .ERR_LIMIT (ERR_LIMIT),
        .WIN_WORDS (WIN_WORDS)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_bit_vld (rx_bit_vld),
        .rx_data    (rx_data),
        .rx_vld     (rx_vld),
        .rx_err     (rx_err),
        .rx_aligned (rx_aligned)
    );

endmodule

// File: rtl/lc34_chk.sv
// Checker: temporal properties on the codec ports, bound to the top.
// Assumes synchronous active-low reset.
module lc34_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_sync,
    input logic [3:0] tx_code,
    input logic       tx_code_vld,
    input logic       rx_bit_vld,
    input logic       rx_vld,
    input logic       rx_err,
    input logic       rx_aligned
);

    logic live_q;  // high once one cycle out of reset has passed

    // Marks cycles whose previous cycle was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r3_code_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && tx_code_vld) |-> $past(tx_valid || tx_sync));

    a_r4_sync_always_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(tx_sync)) |-> tx_code_vld);

    a_r5_no_flat_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_code_vld |-> (tx_code != 4'b0000 && tx_code != 4'b1111));

    a_r9_err_excludes_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_vld && rx_err));

    a_r12_vld_needs_align: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> rx_aligned);

    a_r10_drop_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_aligned) |-> rx_err);

    a_r6_align_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $rose(rx_aligned)) |-> $past(rx_bit_vld));

    a_r7_word_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (rx_vld || rx_err)) |-> $past(rx_bit_vld));

endmodule

bind lc34_codec lc34_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .tx_sync     (tx_sync),
    .tx_code     (tx_code),
    .tx_code_vld (tx_code_vld),
    .rx_bit_vld  (rx_bit_vld),
    .rx_vld      (rx_vld),
    .rx_err      (rx_err),
    .rx_aligned  (rx_aligned)
);

// File: tb/tb_lc34_codec.sv
// Scoreboard bench: drivers push expected code words and data into queues,
// a falling-edge monitor pops and compares as the design produces them.
module tb_lc34_codec;

    localparam int CLK_PERIOD = 10;
    localparam int N1 = 30;
    localparam int N2 = 26;
    localparam int SLIP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_sync = 1'b0;
    logic [3:0] tx_code;
    logic       tx_code_vld;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic [2:0] rx_data;
    logic       rx_vld;
    logic       rx_err;
    logic       rx_aligned;

    lc34_codec dut (
        .clk(clk), .rst_n(rst_n),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sync(tx_sync),
        .tx_code(tx_code), .tx_code_vld(tx_code_vld),
        .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rx_data(rx_data), .rx_vld(rx_vld), .rx_err(rx_err), .rx_aligned(rx_aligned)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    int   err_seen = 0;
    bit   done = 1'b0;
    bit   expect_err = 1'b0;
    logic [3:0] enc_q[$];
    logic [2:0] rx_q[$];
    bit   stream[$];
    bit   m_odd = 1'b0;
    int   m_sidx = 0;
    logic [3:0] mon_code;
    logic [2:0] mon_data;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected code words from R1 and R2
    function automatic logic [3:0] model_code(logic [2:0] d, bit odd);
        case (d)
            3'd0: return 4'b0011;
            3'd1: return 4'b0101;
            3'd2: return 4'b0110;
            3'd3: return 4'b1001;
            3'd4: return 4'b1010;
            3'd5: return 4'b1100;
            3'd6: return odd ? 4'b1011 : 4'b0100;
            default: return odd ? 4'b1101 : 4'b0010;
        endcase
    endfunction

    // Expected sync words from R4
    function automatic logic [3:0] model_sync(int i);
        case (i)
            0: return 4'b0111;
            1: return 4'b1110;
            2: return 4'b1000;
            default: return 4'b0001;
        endcase
    endfunction

    // One transmit cycle; predicts the code word per R3 and R4
    task automatic tx_cycle(logic [2:0] d, bit v, bit s);
        tx_data = d; tx_valid = v; tx_sync = s;
        if (s) begin
            if (m_sidx == 0) m_odd = 1'b0;
            enc_q.push_back(model_sync(m_sidx));
            m_odd = ~m_odd;
            m_sidx = (m_sidx + 1) % 4;
        end else begin
            m_sidx = 0;
            if (v) begin
                enc_q.push_back(model_code(d, m_odd));
                rx_q.push_back(d);
                m_odd = ~m_odd;
            end
        end
        @(negedge clk);
        tx_valid = 1'b0; tx_sync = 1'b0;
    endtask

    task automatic send_bit(bit b);
        rx_bit = b; rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_word(logic [3:0] w);
        for (int b = 3; b >= 0; b--) send_bit(w[b]);
    endtask

    // Monitor: compares outputs one clock after their cause
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_code_vld) begin
                if (enc_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected code word", int'(tx_code), -1);
                end else begin
                    mon_code = enc_q.pop_front();
                    chk(tx_code == mon_code, "R1/R2/R4", "code word", int'(tx_code), int'(mon_code));
                end
                for (int b = 3; b >= 0; b--) stream.push_back(tx_code[b]);
            end
            if (rx_vld) begin
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected rx_vld", int'(rx_data), -1);
                end else begin
                    mon_data = rx_q.pop_front();
                    chk(rx_data == mon_data, "R7", "decoded data", int'(rx_data), int'(mon_data));
                end
            end
            if (rx_err) begin
                err_seen++;
                if (!expect_err) chk(1'b0, "R12/R8", "unexpected rx_err", 1, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(tx_code_vld == 1'b0, "R11", "tx_code_vld in reset", int'(tx_code_vld), 0);
        chk(rx_vld == 1'b0, "R11", "rx_vld in reset", int'(rx_vld), 0);
        chk(rx_err == 1'b0, "R11", "rx_err in reset", int'(rx_err), 0);
        chk(rx_aligned == 1'b0, "R11", "rx_aligned in reset", int'(rx_aligned), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Encoder: partial sync leaves odd position, full sync forces even (R4)
        for (int i = 0; i < 3; i++) tx_cycle(3'd0, 1'b0, 1'b1);
        tx_cycle(3'd5, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) tx_cycle(3'(i + 2), 1'b1, 1'b1);
        for (int i = 0; i < N1; i++) begin
            if (i % 5 == 2) tx_cycle(3'($urandom_range(0, 7)), 1'b0, 1'b0); // R3 idle
            tx_cycle((i < 8) ? 3'(i) : 3'($urandom_range(0, 7)), 1'b1, 1'b0);
        end
        for (int i = 0; i < 4; i++) tx_cycle(3'd0, 1'b0, 1'b1);
        for (int i = 0; i < N2; i++) tx_cycle((i % 3 == 0) ? 3'd6 + 3'(i % 2) : 3'($urandom_range(0, 7)), 1'b1, 1'b0);
        tx_cycle(3'd0, 1'b0, 1'b0);
        tx_cycle(3'd0, 1'b0, 1'b0);
        chk(enc_q.size() == 0, "R3", "code words outstanding", enc_q.size(), 0);
        chk(stream.size() == (3 + 4 + N1 + 4 + N2) * 4, "R3", "stream bits", stream.size(), (3 + 4 + N1 + 4 + N2) * 4);

        // R5 run length on the serialised stream
        begin
            int run = 1;
            int maxrun = 1;
            for (int i = 1; i < stream.size(); i++) begin
                run = (stream[i] == stream[i-1]) ? run + 1 : 1;
                if (run > maxrun) maxrun = run;
            end
            chk(maxrun <= 6, "R5", "longest run", maxrun, 6);
        end

        // Loopback with bit slip and gapped enables (R6, R7, R8)
        for (int i = 0; i < SLIP; i++) send_bit(1'($urandom_range(0, 1)));
        for (int i = 0; i < stream.size(); i++) begin
            if (i % 7 == 6) begin
                rx_bit = ~rx_bit;
                @(negedge clk);
            end
            send_bit(stream[i]);
            if (i == 12 + 14) chk(rx_aligned == 1'b0, "R6", "aligned before last sync bit", int'(rx_aligned), 0);
            if (i == 12 + 15) chk(rx_aligned == 1'b1, "R6", "aligned after last sync bit", int'(rx_aligned), 1);
        end
        repeat (2) @(negedge clk);
        chk(rx_q.size() == 0, "R7", "data words outstanding", rx_q.size(), 0);
        chk(err_seen == 0, "R8", "errors on legal stream", err_seen, 0);
        chk(rx_aligned == 1'b1, "R6", "aligned after loopback", int'(rx_aligned), 1);

        // Error burst across a window edge: words 61..72 after alignment (R9, R10)
        expect_err = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            logic [3:0] w;
            w = (k == 1) ? 4'b1011 : (k == 2) ? 4'b0100 : ((k % 2) ? 4'b1111 : 4'b0000);
            send_word(w);
            chk(rx_err == 1'b1, "R9", "error pulse", int'(rx_err), 1);
            chk(rx_vld == 1'b0, "R9", "no data on error", int'(rx_vld), 0);
            chk(rx_aligned == (k < 12), "R10", "aligned during burst", int'(rx_aligned), int'(k < 12));
        end
        @(negedge clk);
        expect_err = 1'b0;

        // Unaligned garbage, then realignment and decode (R12, R6, R7)
        send_word(4'b0000);
        send_bit(1'b1);
        for (int i = 0; i < 16; i++) begin
            send_bit(i < 4 ? (i != 0) : i < 8 ? (i != 7) : i < 12 ? (i == 8) : (i == 15));
            if (i == 14) chk(rx_aligned == 1'b0, "R6", "realign before last bit", int'(rx_aligned), 0);
        end
        chk(rx_aligned == 1'b1, "R6", "realign after last bit", int'(rx_aligned), 1);
        rx_q.push_back(3'd6); rx_q.push_back(3'd7); rx_q.push_back(3'd3); rx_q.push_back(3'd6);
        send_word(4'b0100);
        send_word(4'b1101);
        send_word(4'b1001);
        send_word(4'b1011);
        repeat (2) @(negedge clk);
        chk(rx_q.size() == 0, "R7", "realigned words outstanding", rx_q.size(), 0);
        chk(err_seen == 12, "R9", "total error pulses", err_seen, 12);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule